// File: doc/BRIEF.md
# Audio Filter Control Registers and Output Mixer

This block is the register and mixing shell around a two-integrator audio filter. A host writes four byte-wide configuration registers: the 11-bit cutoff split over two of them, resonance with per-channel routing, and mute, mode and volume. The host can read any of them back in the same layout. The block takes three voice channels and one external channel as 20-bit signed samples and reduces each to 13 bits. Each channel then goes either into the filter-input sum or into the bypass sum.

The integrators are outside this block. The filter-input sum leaves on a port, together with the cutoff and resonance fields. The three filter state values (low-pass, band-pass, high-pass) come back in on ports. The output mixer adds the bypass sum, the state values chosen by the mode field, and a fixed offset of -454, then multiplies the result by the 4-bit volume. A filter-enable input sends every channel around the filter and removes the filter's contribution.

Top module: `fltmix_top`

## Requirements
- R1: A write to address 0 loads cutoff bits 10:3 from the data byte and leaves cutoff bits 2:0 unchanged.
- R2: A write to address 1 loads cutoff bits 2:0 from data bits 2:0 and leaves cutoff bits 10:3 unchanged.
- R3: A write to address 2 stores the resonance from data bits 7:4 and the routing enables from data bits 3:0. Bit 0 routes voice 1, bit 1 voice 2, bit 2 voice 3 and bit 3 the external channel. The resonance appears on `reso_o`.
- R4: A write to address 3 stores the voice-3 mute from data bit 7, the mode from data bits 6:4 and the volume from data bits 3:0.
- R5: Reading address 0 returns cutoff bits 10:3. Reading address 1 returns cutoff bits 2:0 in bits 2:0, with zeros above. Addresses 2 and 3 read back in the layouts of R3 and R4.
- R6: Each 20-bit input is reduced to 13 bits by an arithmetic right shift of 7, so that -1 stays -1 and 127 becomes 0.
- R7: With the filter enabled, each channel whose routing bit is set adds into `filt_sum_o`. Each channel whose routing bit is clear adds into the bypass sum.
- R8: Voice 3 is forced to zero only while the mute bit is set and routing bit 2 is clear. While voice 3 is routed into the filter, the mute has no effect.
- R9: Mode bit 0 adds the low-pass state, bit 1 the band-pass state and bit 2 the high-pass state into the filter contribution, each with weight one.
- R10: `mix_o` equals (bypass sum + filter contribution - 454) times the volume. A volume of zero gives zero.
- R11: While `flt_en` is low, all four channels go to the bypass sum, `filt_sum_o` is zero and the mode field contributes nothing.
- R12: A synchronous active-low reset clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Combinational read data |
| flt_en | input | 1 | Filter enable; low sends every channel around the filter |
| v1_in | input | 20 | Voice 1 sample, signed |
| v2_in | input | 20 | Voice 2 sample, signed |
| v3_in | input | 20 | Voice 3 sample, signed |
| ext_in | input | 20 | External channel sample, signed |
| lp_st | input | 16 | Low-pass state from the integrators, signed |
| bp_st | input | 16 | Band-pass state from the integrators, signed |
| hp_st | input | 16 | High-pass state from the integrators, signed |
| cutoff_o | output | 11 | Current cutoff setting |
| reso_o | output | 4 | Current resonance setting |
| filt_sum_o | output | 15 | Filter-input sum, signed |
| mix_o | output | 25 | Mixed, offset and volume-scaled output, signed |

## Verification
The hardest case to reach from the ports is the mute override. The mute bit silences voice 3 only while its routing bit is clear, so the bench has to set the mute and the routing bit in two separate register writes. It drives a distinctive voice-3 value and reads both `filt_sum_o` and `mix_o` under each combination. The bench also steps through all sixteen routing codes and all eight mode codes, with negative and non-multiple-of-128 inputs that expose the rounding of the arithmetic shift.

// File: rtl/fltmix_pkg.sv
// Package: shared constants, register addresses and configuration record
// for the filter control and mixer block.
// Assumes: four input channels, with voice 3 at index 2.
package fltmix_pkg;

    localparam int CUT_W     = 11;
    localparam int NCH       = 4;
    localparam int V3_IDX    = 2;
    // Fixed mixer offset: (-4095*255/18) truncated, then arithmetic >> 7 = -454
    localparam int DC_OFFSET = (-4095 * 255 / 18) >>> 7;

    typedef enum logic [1:0] {
        ADR_CUT_HI   = 2'd0,
        ADR_CUT_LO   = 2'd1,
        ADR_RES_RT   = 2'd2,
        ADR_MODE_VOL = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [CUT_W-1:0] cutoff;
        logic [3:0]       reso;
        logic [3:0]       route;
        logic             mute;
        logic [2:0]       mode;
        logic [3:0]       vol;
    } cfg_t;

endpackage

// File: rtl/fltmix_regs.sv
// Module: fltmix_regs
// Holds the four host-visible configuration registers and serves
// combinational readback in the same bit layouts.
// Assumes: single write port, one byte per cycle, synchronous active-low reset.
module fltmix_regs
    import fltmix_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [1:0] rd_addr,
    output logic [7:0] rd_data,
    output cfg_t       cfg
);

    localparam int LO_W = 3;
    localparam int HI_W = CUT_W - LO_W;

    // Register update: reset clears all, a write loads the addressed fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                ADR_CUT_HI:   cfg.cutoff[CUT_W-1:LO_W] <= wr_data[HI_W-1:0];
                ADR_CUT_LO:   cfg.cutoff[LO_W-1:0]     <= wr_data[LO_W-1:0];
                ADR_RES_RT: begin
                    cfg.reso  <= wr_data[7:4];
                    cfg.route <= wr_data[3:0];
                end
                ADR_MODE_VOL: begin
                    cfg.mute <= wr_data[7];
                    cfg.mode <= wr_data[6:4];
                    cfg.vol  <= wr_data[3:0];
                end
                default: ;
            endcase
        end
    end

    // Readback multiplexer: returns each register in its write layout
    always_comb begin
        case (reg_addr_e'(rd_addr))
            ADR_CUT_HI:   rd_data = cfg.cutoff[CUT_W-1:LO_W];
            ADR_CUT_LO:   rd_data = {{(8-LO_W){1'b0}}, cfg.cutoff[LO_W-1:0]};
            ADR_RES_RT:   rd_data = {cfg.reso, cfg.route};
            ADR_MODE_VOL: rd_data = {cfg.mute, cfg.mode, cfg.vol};
            default:      rd_data = '0;
        endcase
    end

    AST_CUT_HI_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADR_CUT_HI) |=>
            (cfg.cutoff[CUT_W-1:LO_W] == $past(wr_data)) &&
            (cfg.cutoff[LO_W-1:0] == $past(cfg.cutoff[LO_W-1:0]))); // R1

    AST_CUT_LO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADR_CUT_LO) |=>
            (cfg.cutoff[LO_W-1:0] == $past(wr_data[LO_W-1:0])) &&
            (cfg.cutoff[CUT_W-1:LO_W] == $past(cfg.cutoff[CUT_W-1:LO_W]))); // R2

endmodule

// File: rtl/fltmix_router.sv
// Module: fltmix_router
// Scales each input channel by an arithmetic shift, applies the voice-3
// mute (only while voice 3 bypasses the filter) and splits the channels
// into the filter-input sum and the bypass sum.
// Assumes: routing bit i belongs to channel i; voice 3 sits at V3_IDX.
module fltmix_router
    import fltmix_pkg::*;
#(
    parameter int IN_W  = 20,
    parameter int SHIFT = 7,
    parameter int SC_W  = IN_W - SHIFT,
    parameter int ACC_W = SC_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flt_en,
    input  logic [NCH-1:0]          route,
    input  logic                    mute,
    input  logic signed [IN_W-1:0]  ch_in [NCH],
    output logic signed [ACC_W-1:0] filt_sum,
    output logic signed [ACC_W-1:0] byp_sum
);

    logic signed [SC_W-1:0]  scaled    [NCH];
    logic signed [SC_W-1:0]  gated     [NCH];
    logic signed [ACC_W-1:0] filt_part [NCH];
    logic signed [ACC_W-1:0] byp_part  [NCH];
    logic [NCH-1:0]          to_filt;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign scaled[g] = SC_W'(ch_in[g] >>> SHIFT);
        if (g == V3_IDX) begin : g_mute
            assign gated[g] = (mute && !route[g]) ? '0 : scaled[g];
        end else begin : g_pass
            assign gated[g] = scaled[g];
        end
        assign to_filt[g]   = flt_en & route[g];
        assign filt_part[g] = to_filt[g] ? ACC_W'(gated[g]) : '0;
        assign byp_part[g]  = to_filt[g] ? '0 : ACC_W'(gated[g]);
    end

    // Summing tree: accumulates the per-channel shares into the two sums
    always_comb begin
        filt_sum = '0;
        byp_sum  = '0;
        for (int i = 0; i < NCH; i++) begin
            filt_sum = filt_sum + filt_part[i];
            byp_sum  = byp_sum + byp_part[i];
        end
    end

    logic signed [ACC_W:0] split_total;
    logic signed [ACC_W:0] gated_total;
    logic signed [ACC_W:0] others_total;

    // Check sums for the assertions: totals taken before routing
    always_comb begin
        split_total  = (ACC_W+1)'(filt_sum) + (ACC_W+1)'(byp_sum);
        gated_total  = '0;
        others_total = '0;
        for (int i = 0; i < NCH; i++) begin
            gated_total = gated_total + (ACC_W+1)'(gated[i]);
            if (i != V3_IDX) others_total = others_total + (ACC_W+1)'(scaled[i]);
        end
    end

    AST_SPLIT_CONSERVES: assert property (@(posedge clk) disable iff (!rst_n)
        split_total == gated_total); // R7

    AST_V3_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
        (mute && !route[V3_IDX]) |-> split_total == others_total); // R8

    AST_BYPASS_EMPTY_FILT: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_en |-> filt_sum == '0); // R11

endmodule

// File: rtl/fltmix_mixer.sv
// Module: fltmix_mixer
// Adds the filter states chosen by the mode field to the bypass sum,
// applies the fixed DC offset and multiplies by the unsigned volume.
// Assumes: SUM_W and OUT_W are large enough for the worst-case sum.
module fltmix_mixer
    import fltmix_pkg::*;
#(
    parameter int ACC_W   = 15,
    parameter int STATE_W = 16,
    parameter int FS_W    = STATE_W + 2,
    parameter int SUM_W   = ((ACC_W > FS_W) ? ACC_W : FS_W) + 2,
    parameter int OUT_W   = SUM_W + 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flt_en,
    input  logic [2:0]                mode,
    input  logic [3:0]                vol,
    input  logic signed [ACC_W-1:0]   byp_sum,
    input  logic signed [STATE_W-1:0] lp_st,
    input  logic signed [STATE_W-1:0] bp_st,
    input  logic signed [STATE_W-1:0] hp_st,
    output logic signed [OUT_W-1:0]   mix_o
);

    logic [2:0]              sel;
    logic signed [FS_W-1:0]  fsel;
    logic signed [SUM_W-1:0] total;

    // Mode selection: picks low-, band- and high-pass states with unit weight
    always_comb begin
        sel  = flt_en ? mode : 3'b000;
        fsel = '0;
        if (sel[0]) fsel = fsel + FS_W'(lp_st);
        if (sel[1]) fsel = fsel + FS_W'(bp_st);
        if (sel[2]) fsel = fsel + FS_W'(hp_st);
    end

    // Output stage: sum, offset and volume scaling
    always_comb begin
        total = SUM_W'(byp_sum) + SUM_W'(fsel) + SUM_W'(DC_OFFSET);
        mix_o = OUT_W'(total) * OUT_W'($signed({1'b0, vol}));
    end

    AST_VOL_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (vol == 4'd0) |-> mix_o == '0); // R10

endmodule

// File: rtl/fltmix_top.sv
// Module: fltmix_top
// Register shell and output mixer of a three-voice audio filter. It holds
// the configuration registers, routes the scaled channels into or around
// the filter, and mixes the returned filter states into the output.
// Assumes: the integrators outside consume filt_sum_o, cutoff_o and reso_o
// and return the three state values.
module fltmix_top
    import fltmix_pkg::*;
#(
    parameter int IN_W    = 20,
    parameter int SHIFT   = 7,
    parameter int STATE_W = 16,
    localparam int SC_W   = IN_W - SHIFT,
    localparam int ACC_W  = SC_W + 2,
    localparam int FS_W   = STATE_W + 2,
    localparam int SUM_W  = ((ACC_W > FS_W) ? ACC_W : FS_W) + 2,
    localparam int OUT_W  = SUM_W + 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [1:0]                wr_addr,
    input  logic [7:0]                wr_data,
    input  logic [1:0]                rd_addr,
    output logic [7:0]                rd_data,
    input  logic                      flt_en,
    input  logic signed [IN_W-1:0]    v1_in,
    input  logic signed [IN_W-1:0]    v2_in,
    input  logic signed [IN_W-1:0]    v3_in,
    input  logic signed [IN_W-1:0]    ext_in,
    input  logic signed [STATE_W-1:0] lp_st,
    input  logic signed [STATE_W-1:0] bp_st,
    input  logic signed [STATE_W-1:0] hp_st,
    output logic [CUT_W-1:0]          cutoff_o,
    output logic [3:0]                reso_o,
    output logic signed [ACC_W-1:0]   filt_sum_o,
    output logic signed [OUT_W-1:0]   mix_o
);

    cfg_t                    cfg;
    logic signed [IN_W-1:0]  ch_arr [NCH];
    logic signed [ACC_W-1:0] byp_sum;

    // Channel gather: voice 1..3 then the external channel, matching route bits
    always_comb begin
        ch_arr[0] = v1_in;
        ch_arr[1] = v2_in;
        ch_arr[2] = v3_in;
        ch_arr[3] = ext_in;
    end

    fltmix_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .cfg     (cfg)
    );

    fltmix_router #(
        .IN_W  (IN_W),
        .SHIFT (SHIFT),
        .SC_W  (SC_W),
        .ACC_W (ACC_W)
    ) u_router (
        .clk      (clk),
        .rst_n    (rst_n),
        .flt_en   (flt_en),
        .route    (cfg.route),
        .mute     (cfg.mute),
        .ch_in    (ch_arr),
        .filt_sum (filt_sum_o),
        .byp_sum  (byp_sum)
    );

    fltmix_mixer #(
        .ACC_W   (ACC_W),
        .STATE_W (STATE_W),
        .FS_W    (FS_W),
        .SUM_W   (SUM_W),
        .OUT_W   (OUT_W)
    ) u_mixer (
        .clk     (clk),
        .rst_n   (rst_n),
        .flt_en  (flt_en),
        .mode    (cfg.mode),
        .vol     (cfg.vol),
        .byp_sum (byp_sum),
        .lp_st   (lp_st),
        .bp_st   (bp_st),
        .hp_st   (hp_st),
        .mix_o   (mix_o)
    );

    assign cutoff_o = cfg.cutoff;
    assign reso_o   = cfg.reso;

endmodule

// File: tb/fltmix_top_tb_top.sv
// Directed bench for fltmix_top: one task per scenario, each checking its
// own results against values worked out from the requirements.
module fltmix_top_tb_top;

    localparam int CLK_PERIOD = 10;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wr_en = 1'b0;
    logic [1:0]         wr_addr = '0;
    logic [7:0]         wr_data = '0;
    logic [1:0]         rd_addr = '0;
    logic [7:0]         rd_data;
    logic               flt_en = 1'b1;
    logic signed [19:0] v1 = '0, v2 = '0, v3 = '0, ve = '0;
    logic signed [15:0] lp = '0, bp = '0, hp = '0;
    logic [10:0]        cutoff_o;
    logic [3:0]         reso_o;
    logic signed [14:0] filt_sum_o;
    logic signed [24:0] mix_o;

    int n_tests = 0;
    int n_fail  = 0;

    // Shadow of the programmed fields, kept by the write tasks
    logic [3:0] s_route = '0;
    logic       s_mute  = 1'b0;
    logic [2:0] s_mode  = '0;
    logic [3:0] s_vol   = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fltmix_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .flt_en(flt_en), .v1_in(v1), .v2_in(v2), .v3_in(v3), .ext_in(ve),
        .lp_st(lp), .bp_st(bp), .hp_st(hp), .cutoff_o(cutoff_o),
        .reso_o(reso_o), .filt_sum_o(filt_sum_o), .mix_o(mix_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 2'd2) s_route = d[3:0];
        if (a == 2'd3) begin s_mute = d[7]; s_mode = d[6:4]; s_vol = d[3:0]; end
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    function automatic int sc(input logic signed [19:0] x);
        return int'(x) >>> 7;
    endfunction

    // Expected filter-input sum and mixer output from the requirements
    function automatic void model(output int f, output int m);
        int ch [4];
        int b, fs;
        ch[0] = sc(v1); ch[1] = sc(v2); ch[2] = sc(v3); ch[3] = sc(ve);
        if (s_mute && !s_route[2]) ch[2] = 0;
        f = 0; b = 0;
        for (int i = 0; i < 4; i++) begin
            if (flt_en && s_route[i]) f += ch[i];
            else b += ch[i];
        end
        fs = 0;
        if (flt_en) begin
            if (s_mode[0]) fs += int'(lp);
            if (s_mode[1]) fs += int'(bp);
            if (s_mode[2]) fs += int'(hp);
        end
        m = (b + fs - 454) * int'(s_vol);
    endfunction

    task automatic check_out(input string req);
        int f, m;
        #1;
        model(f, m);
        check(req, int'(filt_sum_o), f);
        check(req, int'(mix_o), m);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        s_route = '0; s_mute = 1'b0; s_mode = '0; s_vol = '0;
    endtask

    task automatic t_reset();
        int v;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R12 reset readback", v, 0);
        end
        check("R12 reset cutoff", int'(cutoff_o), 0);
        check("R12 reset reso", int'(reso_o), 0);
        check("R12 reset mix", int'(mix_o), 0);
    endtask

    task automatic t_cutoff();
        int v;
        wr(2'd0, 8'hA5);
        check("R1 hi load", int'(cutoff_o), 11'h528);
        wr(2'd1, 8'hFE);
        check("R2 lo load keeps hi", int'(cutoff_o), 11'h52E);
        rd(2'd0, v); check("R5 hi readback", v, 8'hA5);
        rd(2'd1, v); check("R5 lo readback", v, 8'h06);
        wr(2'd0, 8'h3C);
        check("R1 hi load keeps lo", int'(cutoff_o), 11'h1E6);
    endtask

    task automatic t_fields();
        int v;
        wr(2'd2, 8'h9A);
        check("R3 resonance", int'(reso_o), 9);
        rd(2'd2, v); check("R3 R5 res/route readback", v, 8'h9A);
        wr(2'd3, 8'hD7);
        rd(2'd3, v); check("R4 R5 mode/vol readback", v, 8'hD7);
    endtask

    task automatic t_scale();
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h01);
        v1 = 20'sd12800; v2 = -20'sd1; v3 = 20'sd127; ve = -20'sd12801;
        #1;
        check("R6 shift rounding", int'(mix_o), (100 - 1 + 0 - 101 - 454));
        check_out("R6 scale");
    endtask

    task automatic t_route();
        v1 = 20'sd1280; v2 = -20'sd25600; v3 = 20'sd64000; ve = 20'sd3840;
        wr(2'd3, 8'h0F);
        for (int r = 0; r < 16; r++) begin
            wr(2'd2, 8'(r));
            check_out("R7 routing");
        end
    endtask

    task automatic t_mute();
        v3 = 20'sd51200;
        wr(2'd3, 8'h82);
        wr(2'd2, 8'h00);
        #1;
        check("R8 muted bypass", int'(mix_o), (10 - 200 + 30 - 454) * 2);
        check_out("R8 muted");
        wr(2'd2, 8'h04);
        #1;
        check("R8 mute ignored when routed", int'(filt_sum_o), 400);
        check_out("R8 routed");
        wr(2'd3, 8'h02);
        wr(2'd2, 8'h00);
        check_out("R8 unmuted");
    endtask

    task automatic t_mode();
        lp = 16'sd1000; bp = -16'sd2000; hp = 16'sd300;
        wr(2'd2, 8'h05);
        for (int md = 0; md < 8; md++) begin
            wr(2'd3, {1'b0, 3'(md), 4'd3});
            check_out("R9 R10 mode");
        end
        wr(2'd3, 8'h70);
        check("R10 volume zero", int'(mix_o), 0);
        wr(2'd3, 8'h7F);
        check_out("R10 volume max");
    endtask

    task automatic t_disable();
        wr(2'd2, 8'h0F);
        wr(2'd3, 8'h7A);
        flt_en = 1'b0;
        #1;
        check("R11 filter input zero", int'(filt_sum_o), 0);
        check("R11 all bypass", int'(mix_o), (10 - 200 + 400 + 30 - 454) * 10);
        check_out("R11 disabled");
        flt_en = 1'b1;
        check_out("R11 re-enabled");
    endtask

    task automatic t_reset_again();
        int v;
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'h07);
        do_reset();
        rd(2'd0, v); check("R12 cutoff cleared", v, 0);
        rd(2'd3, v); check("R12 mode/vol cleared", v, 0);
        rd(2'd2, v); check("R12 route cleared", v, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        t_reset();
        t_cutoff();
        t_fields();
        t_scale();
        t_route();
        t_mute();
        t_mode();
        t_disable();
        t_reset_again();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule